// File: doc/BRIEF.md
# Voice-Group Instruction Sequencer

This block is the control core of a small speech controller. Its program sits in an external synchronous memory that is split into 256 voice groups of `2**IDX_W` instruction slots each. The block runs one group at a time. It fetches a 16-bit word, decodes it and executes it. The instructions can load one of four control registers, jump to another group, hand a play-section request to an audio engine, or halt. Three of the registers drive outputs: a 3-bit stop pattern goes to pins, and the trigger-enable byte and the mode nibble go to the trigger logic. A fourth register, the group pointer, is used only by indirect jumps.

The trigger logic can raise a vector request with a group number from 0 to 7. The request drops the running group at once and restarts execution at slot 0 of that group. If a play request is pending, it is cancelled with an abort pulse. After reset the block waits a programmable number of cycles. It then runs group 32 as its power-on routine. A vector request that arrives during that wait, or during the routine itself, takes priority over it. Groups 8 to 255 can be reached only by jumps.

Instruction word: bits 15:13 hold the opcode, bits 12:9 the condition, bit 8 is unused and bits 7:0 the operand.
- Opcodes: 0 halt, 1 load pointer, 2 load trigger enables, 3 load stop pattern, 4 load mode, 5 direct jump, 6 jump through the pointer, 7 play section.
- Condition values:
  - `0000`: always true. Bits 2:1 are ignored when bit 3 is 0.
  - `0001`: true only on the final global repeat pass, signalled by `final_rep`=1.
  - `1ppl`: true when pin `pp` is at level `l`. Pin `pp` is 0 to 3, which maps to `pin_lvl[0]` to `pin_lvl[3]`, the trigger pins 1 to 4. Level `l` is 1 for high.

The FSM has five states:
- `ST_BOOT`: the start-up wait.
- `ST_FETCH`: the memory read is issued.
- `ST_DECODE`: the instruction is executed.
- `ST_PLAY`: the block waits for done.
- `ST_IDLE`: the block is halted.

Transitions:
- `ST_BOOT` goes to `ST_FETCH` when the delay ends or on a vector request.
- `ST_FETCH` goes to `ST_DECODE`.
- `ST_DECODE` goes to `ST_IDLE` on a halt, to `ST_PLAY` on a play instruction, and to `ST_FETCH` otherwise.
- `ST_PLAY` goes to `ST_FETCH` on done.
- `ST_IDLE` stays until a vector request.
- A vector request sends every state to `ST_FETCH`.

Top module: `voice_seq`

## Requirements
- R1: After reset the block drives `stop_o`=3'b111, `en_o`=8'hFF and `mode_o`=4'hF. The pointer resets to 0. No memory read happens during the start-up wait.
- R2: A load of the stop pattern copies operand bits 2:0 to `stop_o` and ignores bits 7:3. A load of the trigger enables copies all 8 operand bits to `en_o`. A load of the mode copies operand bits 7:4 to `mode_o` and ignores bits 3:0.
- R3: A direct jump (opcode 5) continues at slot 0 of group `operand[6:0]`. Operand bit 7 is ignored, so only groups 0 to 127 can be reached this way.
- R4: An indirect jump (opcode 6) continues at slot 0 of the group held in the pointer, which opcode 1 loads (any group from 0 to 255).
- R5: Opcodes 1, 2, 3, 5 and 6 execute only when their condition holds. Otherwise they do nothing and execution continues with the next slot.
- R6: A mode load (opcode 4) executes whatever its condition field holds.
- R7: A halt (opcode 0) stops all fetching until the next vector request.
- R8: A vector request with `vec_num`=v makes the next cycle read slot 0 of group v, whatever the state. If a play request is pending, `play_abort` pulses for one cycle.
- R9: `BOOT_CYC` cycles after reset, the first memory read is slot 0 of group 32.
- R10: A vector request during the start-up wait preempts it, and group 32 is never read.
- R11: A play instruction (opcode 7) pulses `play_start` for one cycle with `play_arg` equal to the operand. No fetch follows until `play_done` or a vector request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_req | input | 1 | Hardware vector request, one cycle |
| vec_num | input | 3 | Vector group number 0 to 7 |
| pin_lvl | input | 4 | Live levels of trigger pins 1 to 4 |
| final_rep | input | 1 | High on the final global repeat pass |
| mem_rd | output | 1 | Program memory read strobe |
| mem_addr | output | 8+IDX_W | Program address {group, slot} |
| mem_data | input | 16 | Read data, valid the cycle after `mem_rd` |
| play_start | output | 1 | One-cycle play-section request |
| play_arg | output | 8 | Section operand of the request |
| play_done | input | 1 | Section finished |
| play_abort | output | 1 | Pending section cancelled by a vector request |
| stop_o | output | 3 | Stop outputs, bit 0 is the first pin |
| en_o | output | 8 | Trigger-edge enables for the trigger logic |
| mode_o | output | 4 | Mode bits for the trigger logic |

## Verification
Each instruction costs two cycles: the fetch, then the decode, after which its effect appears on the ports. A vector request seen at an edge causes a read of the vector slot in the very next cycle. A single-instruction group therefore settles within four cycles of the request. Register effects of the power-on group appear about `BOOT_CYC`+4 cycles after reset. The bench drives stimulus and samples on the falling edge. It waits at least twice the longest such latency before comparing. The tests that expect no fetch count memory reads over a window of ten or more cycles.

// File: rtl/voice_seq_pkg.sv
package voice_seq_pkg;

    localparam int INSTR_W  = 16;
    localparam int GRP_W    = 8;
    localparam int POI_GRP  = 32;

    typedef enum logic [2:0] {
        OP_END    = 3'd0,
        OP_LDPTR  = 3'd1,
        OP_LDEN   = 3'd2,
        OP_LDSTOP = 3'd3,
        OP_LDMODE = 3'd4,
        OP_JPIMM  = 3'd5,
        OP_JPPTR  = 3'd6,
        OP_PLAY   = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_FETCH,
        ST_DECODE,
        ST_PLAY,
        ST_IDLE
    } state_e;

    typedef struct packed {
        op_e        op;
        logic [3:0] cond;
        logic       spare;
        logic [7:0] imm;
    } instr_t;

endpackage

// File: rtl/seq_boot_timer.sv
module seq_boot_timer #(
    parameter int BOOT_CYC = 480000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CNT_W = $clog2(BOOT_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BOOT_CYC);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIMIT);
endmodule

// File: rtl/seq_cond_eval.sv
module seq_cond_eval (
    input  logic [3:0] cond,
    input  logic [3:0] pin_lvl,
    input  logic       final_rep,
    output logic       ok
);
    always_comb begin
        if (cond[3])
            ok = (pin_lvl[cond[2:1]] == cond[0]);
        else
            ok = !cond[0] || final_rep;
    end
endmodule

// File: rtl/seq_regs.sv
module seq_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ptr,
    input  logic       wr_en,
    input  logic       wr_stop,
    input  logic       wr_mode,
    input  logic [7:0] wdata,
    output logic [7:0] ptr,
    output logic [7:0] en,
    output logic [2:0] stop,
    output logic [3:0] mode
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr  <= 8'h00;
            en   <= 8'hFF;
            stop <= 3'b111;
            mode <= 4'hF;
        end else begin
            if (wr_ptr)  ptr  <= wdata;
            if (wr_en)   en   <= wdata;
            if (wr_stop) stop <= wdata[2:0];
            if (wr_mode) mode <= wdata[7:4];
        end
    end
endmodule

// File: rtl/voice_seq.sv
module voice_seq
    import voice_seq_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int BOOT_CYC = 480000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vec_req,
    input  logic [2:0]             vec_num,
    input  logic [3:0]             pin_lvl,
    input  logic                   final_rep,
    output logic                   mem_rd,
    output logic [GRP_W+IDX_W-1:0] mem_addr,
    input  logic [INSTR_W-1:0]     mem_data,
    output logic                   play_start,
    output logic [7:0]             play_arg,
    input  logic                   play_done,
    output logic                   play_abort,
    output logic [2:0]             stop_o,
    output logic [7:0]             en_o,
    output logic [3:0]             mode_o
);
    localparam int ADDR_W = GRP_W + IDX_W;
    localparam logic [IDX_W-1:0] SLOT0 = '0;
    localparam logic [GRP_W-1:0] POI   = GRP_W'(POI_GRP);

    state_e            state, state_nx;
    instr_t            ins;
    logic [GRP_W-1:0]  pc_grp;
    logic [IDX_W-1:0]  pc_idx;
    logic              boot_done;
    logic              cond_ok;
    logic              exec;
    logic [7:0]        ptr;

    assign ins  = instr_t'(mem_data);
    assign exec = (state == ST_DECODE) && !vec_req;

    seq_boot_timer #(.BOOT_CYC(BOOT_CYC)) u_boot (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (boot_done)
    );

    seq_cond_eval u_cond (
        .cond      (ins.cond),
        .pin_lvl   (pin_lvl),
        .final_rep (final_rep),
        .ok        (cond_ok)
    );

    seq_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ptr  (exec && ins.op == OP_LDPTR  && cond_ok),
        .wr_en   (exec && ins.op == OP_LDEN   && cond_ok),
        .wr_stop (exec && ins.op == OP_LDSTOP && cond_ok),
        .wr_mode (exec && ins.op == OP_LDMODE),
        .wdata   (ins.imm),
        .ptr     (ptr),
        .en      (en_o),
        .stop    (stop_o),
        .mode    (mode_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (vec_req) begin
            state_nx = ST_FETCH;
        end else begin
            unique case (state)
                ST_BOOT:   if (boot_done) state_nx = ST_FETCH;
                ST_FETCH:  state_nx = ST_DECODE;
                ST_DECODE: begin
                    unique case (ins.op)
                        OP_END:  state_nx = ST_IDLE;
                        OP_PLAY: state_nx = ST_PLAY;
                        default: state_nx = ST_FETCH;
                    endcase
                end
                ST_PLAY:   if (play_done) state_nx = ST_FETCH;
                ST_IDLE:   state_nx = ST_IDLE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // program counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_grp <= '0;
            pc_idx <= '0;
        end else if (vec_req) begin
            pc_grp <= {{(GRP_W-3){1'b0}}, vec_num};
            pc_idx <= SLOT0;
        end else if (state == ST_BOOT && boot_done) begin
            pc_grp <= POI;
            pc_idx <= SLOT0;
        end else if (state == ST_DECODE) begin
            if (ins.op == OP_JPIMM && cond_ok) begin
                pc_grp <= {1'b0, ins.imm[6:0]};
                pc_idx <= SLOT0;
            end else if (ins.op == OP_JPPTR && cond_ok) begin
                pc_grp <= ptr;
                pc_idx <= SLOT0;
            end else if (ins.op != OP_END) begin
                pc_idx <= pc_idx + 1'b1;
            end
        end
    end

    // registered handshake outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            play_start <= 1'b0;
            play_arg   <= '0;
            play_abort <= 1'b0;
        end else begin
            play_start <= exec && ins.op == OP_PLAY;
            play_abort <= vec_req && state == ST_PLAY;
            if (exec && ins.op == OP_PLAY)
                play_arg <= ins.imm;
        end
    end

    assign mem_rd   = (state == ST_FETCH);
    assign mem_addr = ADDR_W'({pc_grp, pc_idx});
endmodule

// File: rtl/voice_seq_chk.sv
module voice_seq_chk #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vec_req,
    input logic [2:0]        vec_num,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              play_start,
    input logic              play_done,
    input logic              play_abort
);
    logic pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending || play_start) && !play_done && !vec_req;
    end

    AST_VEC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> mem_rd && mem_addr == ADDR_W'({$past(vec_num), {IDX_W{1'b0}}})); // R8

    AST_PLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !mem_rd); // R11

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        play_start |=> !play_start); // R11

    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        play_abort |-> $past(vec_req)); // R8
endmodule

bind voice_seq voice_seq_chk #(.ADDR_W(voice_seq_pkg::GRP_W + IDX_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec_req    (vec_req),
    .vec_num    (vec_num),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .play_start (play_start),
    .play_done  (play_done),
    .play_abort (play_abort)
);

// File: tb/voice_seq_test.sv
`timescale 1ns/1ps
module voice_seq_test;
    localparam int IDX_W = 4;
    localparam int BOOT  = 40;
    localparam int AW    = 8 + IDX_W;
    localparam int NVEC  = 12;

    // {instr, pins, final, stop, en, mode}
    localparam logic [35:0] VEC [NVEC] = '{
        {16'h6005, 4'b0000, 1'b0, 3'd5, 8'hFF, 4'hF},
        {16'h60FA, 4'b0000, 1'b0, 3'd2, 8'hFF, 4'hF},
        {16'h6207, 4'b0000, 1'b0, 3'd2, 8'hFF, 4'hF},
        {16'h6207, 4'b0000, 1'b1, 3'd7, 8'hFF, 4'hF},
        {16'h4041, 4'b0000, 1'b0, 3'd7, 8'h41, 4'hF},
        {16'h5A22, 4'b0000, 1'b0, 3'd7, 8'h41, 4'hF},
        {16'h5A22, 4'b0100, 1'b0, 3'd7, 8'h22, 4'hF},
        {16'h5099, 4'b1110, 1'b0, 3'd7, 8'h99, 4'hF},
        {16'h805A, 4'b0000, 1'b0, 3'd7, 8'h99, 4'h5},
        {16'h823F, 4'b0000, 1'b0, 3'd7, 8'h99, 4'h3},
        {16'h7C01, 4'b1000, 1'b0, 3'd7, 8'h99, 4'h3},
        {16'h7C01, 4'b0000, 1'b0, 3'd1, 8'h99, 4'h3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vec_req = 1'b0;
    logic [2:0]    vec_num = '0;
    logic [3:0]    pin_lvl = '0;
    logic          final_rep = 1'b0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_data = '0;
    logic          play_start;
    logic [7:0]    play_arg;
    logic          play_done = 1'b0;
    logic          play_abort;
    logic [2:0]    stop_o;
    logic [7:0]    en_o;
    logic [3:0]    mode_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] mem [1 << AW];
    logic        hit [1 << AW];
    int          fetches;
    logic [AW-1:0] first_addr;
    int          starts;
    int          aborts;
    logic [7:0]  last_arg;

    always #2 clk = ~clk;

    voice_seq #(.IDX_W(IDX_W), .BOOT_CYC(BOOT)) uut (
        .clk(clk), .rst_n(rst_n), .vec_req(vec_req), .vec_num(vec_num),
        .pin_lvl(pin_lvl), .final_rep(final_rep), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_data(mem_data), .play_start(play_start),
        .play_arg(play_arg), .play_done(play_done), .play_abort(play_abort),
        .stop_o(stop_o), .en_o(en_o), .mode_o(mode_o)
    );

    // program memory model and port monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            fetches <= 0;
            starts  <= 0;
            aborts  <= 0;
            for (int i = 0; i < (1 << AW); i++) hit[i] <= 1'b0;
        end else begin
            if (mem_rd) begin
                mem_data <= mem[mem_addr];
                hit[mem_addr] <= 1'b1;
                if (fetches == 0) first_addr <= mem_addr;
                fetches <= fetches + 1;
            end
            if (play_start) begin
                starts   <= starts + 1;
                last_arg <= play_arg;
            end
            if (play_abort) aborts <= aborts + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(input logic [2:0] v);
        @(negedge clk);
        vec_num = v;
        vec_req = 1'b1;
        @(negedge clk);
        vec_req = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f0;
        for (int i = 0; i < (1 << AW); i++) mem[i] = 16'h0000;
        mem[512] = 16'h6000;   // power-on group: stop pattern 0
        do_reset();

        // R1 reset values
        cyc(2);
        check("R1 stop", 32'(stop_o), 32'h7);
        check("R1 en", 32'(en_o), 32'hFF);
        check("R1 mode", 32'(mode_o), 32'hF);
        // R9 quiet during wait, then group 32
        cyc(BOOT - 8);
        check("R9 no fetch during wait", 32'(fetches), 32'd0);
        cyc(20);
        check("R9 first fetch group 32", 32'(first_addr), 32'd512);
        check("R9 power-on group ran", 32'(stop_o), 32'h0);

        // R10 vector during wait preempts power-on group
        do_reset();
        cyc(5);
        fire(3'd3);
        cyc(BOOT + 10);
        check("R10 first fetch vector 3", 32'(first_addr), 32'd48);
        check("R10 group 32 never read", 32'(hit[512]), 32'd0);
        check("R10 stop untouched", 32'(stop_o), 32'h7);

        // R2 R5 R6 table walk through vector 0
        for (int k = 0; k < NVEC; k++) begin
            mem[0] = VEC[k][35:20];
            mem[1] = 16'h0000;
            pin_lvl = VEC[k][19:16];
            final_rep = VEC[k][15];
            fire(3'd0);
            cyc(10);
            check($sformatf("R2/R5/R6 row %0d stop", k), 32'(stop_o), 32'(VEC[k][14:12]));
            check($sformatf("R2/R5/R6 row %0d en", k), 32'(en_o), 32'(VEC[k][11:4]));
            check($sformatf("R2/R6 row %0d mode", k), 32'(mode_o), 32'(VEC[k][3:0]));
        end
        pin_lvl = 4'b0000;
        final_rep = 1'b0;

        // R3 direct jump ignores operand bit 7
        mem[0] = 16'hA085; mem[80] = 16'h6003; mem[81] = 16'h0000;
        fire(3'd0);
        cyc(12);
        check("R3 jumped to group 5", 32'(stop_o), 32'h3);
        check("R3 group 133 not read", 32'(hit[2128]), 32'd0);

        // R4 indirect jump to group 200
        mem[16] = 16'h20C8; mem[17] = 16'hC000;
        mem[3200] = 16'h6006; mem[3201] = 16'h0000;
        fire(3'd1);
        cyc(14);
        check("R4 indirect reached group 200", 32'(hit[3200]), 32'd1);
        check("R4 group 200 executed", 32'(stop_o), 32'h6);

        // R5 conditional jump on pin 2 high
        mem[32] = 16'hB60A; mem[33] = 16'h6004; mem[34] = 16'h0000;
        mem[160] = 16'h6005; mem[161] = 16'h0000;
        fire(3'd2);
        cyc(12);
        check("R5 jump skipped, pin low", 32'(stop_o), 32'h4);
        check("R5 group 10 not read", 32'(hit[160]), 32'd0);
        pin_lvl = 4'b0010;
        fire(3'd2);
        cyc(12);
        check("R5 jump taken, pin high", 32'(stop_o), 32'h5);
        pin_lvl = 4'b0000;

        // R11 play handshake
        mem[64] = 16'hE033; mem[65] = 16'h6002; mem[66] = 16'h0000;
        fire(3'd4);
        cyc(8);
        check("R11 one start pulse", 32'(starts), 32'd1);
        check("R11 section operand", 32'(last_arg), 32'h33);
        f0 = fetches;
        cyc(12);
        check("R11 no fetch while pending", 32'(fetches - f0), 32'd0);
        check("R11 stop held while pending", 32'(stop_o), 32'h5);
        @(negedge clk); play_done = 1'b1;
        @(negedge clk); play_done = 1'b0;
        cyc(10);
        check("R11 resumed after done", 32'(stop_o), 32'h2);

        // R8 vector preempts a pending play
        mem[96] = 16'hE044; mem[97] = 16'h6000; mem[98] = 16'h0000;
        mem[112] = 16'h6005; mem[113] = 16'h0000;
        fire(3'd6);
        cyc(8);
        fire(3'd7);
        cyc(10);
        check("R8 abort pulse", 32'(aborts), 32'd1);
        check("R8 vector 7 group ran", 32'(stop_o), 32'h5);

        // R7 halt stops fetching
        f0 = fetches;
        cyc(20);
        check("R7 no fetch after halt", 32'(fetches - f0), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule